// File: doc/BRIEF.md
# Drop-Through Item Tracking Sorter

This block tracks the class code of every item between an upstream inspection station and a downstream ejection or sorting station on a free-running conveyor. The two stations are not in step with each other. Each time the inspection station reports a result, its class code is written into the lowest empty slot of a small register stack. The stack therefore fills from the bottom upward. The photo-eye at the ejection station marks the arrival of each item. On each arrival, the bottom slot supplies the code for that item, every entry drops one slot, and the old bottom entry is discarded.

The eye level is synchronized and debounced. One clean gap-to-item transition gives exactly one unload. The code taken from the stack is held in a dedicated register for as long as the item blocks the eye, so later loads and shifts cannot change the action on the item in front of the eye. A sort output carries the held code while the item is present. A separate eject output is active only when that held code is the reject code. A load and an unload in the same cycle are both handled. Two sticky flags record a load that arrived at a full stack and an unload that arrived at an empty one.

Top module: `dropfill_sorter`

## Requirements
- R1: After reset the stack is empty, fill_count is 0, sort_valid and eject are 0, and both error flags are 0.
- R2: Each inspection strobe (insp_valid high for one clock) writes insp_code into the lowest empty slot and raises fill_count by one. Codes then leave the stack in the order they were loaded.
- R3: A debounced rise of the eye level takes the bottom entry as the code for the arriving item, shifts every other entry down one slot and lowers fill_count by one.
- R4: When a load and an unload fall in the same clock, the unload shifts first and the new code goes into the slot that is empty after the shift. fill_count is unchanged and the code order is kept.
- R5: An eye level that stays high for fewer than DEBOUNCE clocks (default 4) after synchronization causes no unload: fill_count and the sort outputs do not change.
- R6: An item that keeps the eye blocked for a long time causes exactly one unload.
- R7: While the debounced eye is blocked and a code was taken for that item, sort_valid is 1 and sort_code carries that code. Both return to 0 after the eye clears.
- R8: eject is 1 only while sort_valid is 1 and the held code equals REJECT_CODE (default 1). It is 0 for every other class code.
- R9: Loads that arrive while an item is in front of the eye do not change sort_code or eject for that item.
- R10: A load while fill_count equals DEPTH (default 8), with no unload in the same clock, is dropped. It sets the sticky overflow flag and leaves the stored codes unchanged.
- R11: An unload while the stack is empty sets the sticky underflow flag, and sort_valid stays 0 for that item.
- R12: fill_count always equals the number of stored codes and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eye_raw | input | 1 | Ejection photo-eye level, 1 = item blocking |
| insp_valid | input | 1 | One-clock strobe: an inspection result is ready |
| insp_code | input | CODE_W | Class code of the inspected item |
| sort_valid | output | 1 | An item with a known code is in front of the eye |
| sort_code | output | CODE_W | Held class code of that item (0 when sort_valid is 0) |
| eject | output | 1 | Ejector drive |
| fill_count | output | $clog2(DEPTH+1) | Number of stored codes |
| overflow_err | output | 1 | Sticky: a load arrived at a full stack |
| underflow_err | output | 1 | Sticky: an unload arrived at an empty stack |

## Verification
The bench lines up an inspection strobe with the exact clock in which an item's arrival unloads the stack. A design that shifted after writing, or that moved the pointer only once, would end with a wrong count or would hand a later item the wrong code. It loads a new code while a reject item sits in front of the eye: a design without the hold register would drop the ejector part way through. It also sends a short glitch, keeps the eye blocked for a long time, unloads an empty stack and overfills a full one. A weak debounce would drop codes on the glitch, an edge detector that repeats would drain the stack during the long block, and a stack that wrapped would overwrite the codes that were already waiting.

// File: rtl/dropfill_pkg.sv
package dropfill_pkg;
    // Operation applied to the stack in one clock
    typedef enum logic [1:0] {
        OP_IDLE   = 2'b00,
        OP_UNLOAD = 2'b01,
        OP_LOAD   = 2'b10,
        OP_BOTH   = 2'b11
    } stack_op_e;

    localparam int DEF_DEPTH    = 8;
    localparam int DEF_CODE_W   = 3;
    localparam int DEF_DEBOUNCE = 4;
endpackage

// File: rtl/eye_conditioner.sv
module eye_conditioner #(
    parameter int DEBOUNCE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eye_raw_i,
    output logic level_o,
    output logic unload_o
);
    localparam int DB_W = (DEBOUNCE < 2) ? 1 : $clog2(DEBOUNCE);

    typedef struct packed {
        logic            s1;
        logic            s2;
        logic            filt;
        logic [DB_W-1:0] cnt;
        logic            pulse;
    } eye_st_t;

    eye_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.s1    = eye_raw_i;
        st_d.s2    = st_q.s1;
        st_d.pulse = 1'b0;
        if (st_q.s2 == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == DB_W'(DEBOUNCE - 1)) begin
            st_d.cnt   = '0;
            st_d.filt  = st_q.s2;
            st_d.pulse = st_q.s2;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o  = st_q.filt;
    assign unload_o = st_q.pulse;

    // R6
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unload_o |=> !unload_o);
    // R5
    pulse_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unload_o |-> level_o && !$past(level_o));
endmodule

// File: rtl/slot_stack.sv
module slot_stack
    import dropfill_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int CODE_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [CODE_W-1:0]          code_i,
    input  logic                       unload_i,
    output logic [CODE_W-1:0]          bottom_code_o,
    output logic                       bottom_valid_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       ovf_o,
    output logic                       unf_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][CODE_W-1:0] slot;
        logic [CNT_W-1:0]             cnt;
        logic                         ovf;
        logic                         unf;
    } stk_st_t;

    stk_st_t          st_d, st_q;
    stack_op_e        op;
    logic             want_load, want_unload;
    logic [CNT_W-1:0] mid_cnt;

    always_comb begin
        op          = stack_op_e'({load_i, unload_i});
        want_load   = 1'b0;
        want_unload = 1'b0;
        case (op)
            OP_LOAD:   want_load = 1'b1;
            OP_UNLOAD: want_unload = 1'b1;
            OP_BOTH: begin
                want_load   = 1'b1;
                want_unload = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        mid_cnt = st_q.cnt;
        // unload first: shift down, drop bottom
        if (want_unload) begin
            if (st_q.cnt == '0) begin
                st_d.unf = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    st_d.slot[i] = st_q.slot[i+1];
                end
                st_d.slot[DEPTH-1] = '0;
                mid_cnt = st_q.cnt - 1'b1;
            end
        end
        // then load into the first free slot after the shift
        st_d.cnt = mid_cnt;
        if (want_load) begin
            if (mid_cnt == CNT_W'(DEPTH)) begin
                st_d.ovf = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (mid_cnt == CNT_W'(i)) st_d.slot[i] = code_i;
                end
                st_d.cnt = mid_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bottom_code_o  = st_q.slot[0];
    assign bottom_valid_o = (st_q.cnt != '0);
    assign count_o        = st_q.cnt;
    assign ovf_o          = st_q.ovf;
    assign unf_o          = st_q.unf;

    // R12
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    // R2
    load_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !unload_i && st_q.cnt < CNT_W'(DEPTH)) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);
    // R4
    both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && unload_i && st_q.cnt != '0) |=> $stable(st_q.cnt));
    // R3
    shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unload_i && !load_i && st_q.cnt > 1) |=> st_q.slot[0] == $past(st_q.slot[1]));
    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !unload_i && st_q.cnt == CNT_W'(DEPTH)) |=> $stable(st_q.slot) && st_q.ovf);
    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);
    // R11
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unf |=> st_q.unf);
endmodule

// File: rtl/eject_driver.sv
module eject_driver #(
    parameter int          CODE_W      = 3,
    parameter logic [CODE_W-1:0] REJECT_CODE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level_i,
    input  logic              unload_i,
    input  logic [CODE_W-1:0] bottom_code_i,
    input  logic              bottom_valid_i,
    output logic              sort_valid_o,
    output logic [CODE_W-1:0] sort_code_o,
    output logic              eject_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              valid;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (unload_i) begin
            st_d.valid = bottom_valid_i;
            st_d.code  = bottom_valid_i ? bottom_code_i : '0;
        end else if (!level_i) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sort_valid_o = level_i && st_q.valid;
    assign sort_code_o  = sort_valid_o ? st_q.code : '0;
    assign eject_o      = sort_valid_o && (st_q.code == REJECT_CODE);

    // R8
    eject_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eject_o |-> level_i);
    // R9
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sort_valid_o && level_i) |=> (!sort_valid_o || $stable(sort_code_o)));
    // R7
    clear_on_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !level_i |-> !sort_valid_o);
endmodule

// File: rtl/dropfill_sorter.sv
module dropfill_sorter
    import dropfill_pkg::*;
#(
    parameter int                DEPTH       = DEF_DEPTH,
    parameter int                CODE_W      = DEF_CODE_W,
    parameter int                DEBOUNCE    = DEF_DEBOUNCE,
    parameter logic [CODE_W-1:0] REJECT_CODE = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       eye_raw,
    input  logic                       insp_valid,
    input  logic [CODE_W-1:0]          insp_code,
    output logic                       sort_valid,
    output logic [CODE_W-1:0]          sort_code,
    output logic                       eject,
    output logic [$clog2(DEPTH+1)-1:0] fill_count,
    output logic                       overflow_err,
    output logic                       underflow_err
);
    logic              eye_level, unload;
    logic [CODE_W-1:0] bottom_code;
    logic              bottom_valid;

    eye_conditioner #(.DEBOUNCE(DEBOUNCE)) eye_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .eye_raw_i (eye_raw),
        .level_o   (eye_level),
        .unload_o  (unload)
    );

    slot_stack #(.DEPTH(DEPTH), .CODE_W(CODE_W)) stack_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_i         (insp_valid),
        .code_i         (insp_code),
        .unload_i       (unload),
        .bottom_code_o  (bottom_code),
        .bottom_valid_o (bottom_valid),
        .count_o        (fill_count),
        .ovf_o          (overflow_err),
        .unf_o          (underflow_err)
    );

    eject_driver #(.CODE_W(CODE_W), .REJECT_CODE(REJECT_CODE)) drv_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .level_i        (eye_level),
        .unload_i       (unload),
        .bottom_code_i  (bottom_code),
        .bottom_valid_i (bottom_valid),
        .sort_valid_o   (sort_valid),
        .sort_code_o    (sort_code),
        .eject_o        (eject)
    );

    // R11
    empty_unload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unload && !bottom_valid) |=> underflow_err);
endmodule

// File: tb/dropfill_sorter_tb.sv
module dropfill_sorter_tb_top;
    localparam int DEPTH = 8;
    localparam int CODE_W = 3;
    localparam int DB = 4;
    localparam int SETTLE = DB + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eye_raw = 1'b0;
    logic insp_valid = 1'b0;
    logic [CODE_W-1:0] insp_code = '0;
    logic sort_valid, eject, overflow_err, underflow_err;
    logic [CODE_W-1:0] sort_code;
    logic [$clog2(DEPTH+1)-1:0] fill_count;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    dropfill_sorter #(.DEPTH(DEPTH), .CODE_W(CODE_W), .DEBOUNCE(DB), .REJECT_CODE(3'd1)) dut_i (
        .clk(clk), .rst_n(rst_n), .eye_raw(eye_raw), .insp_valid(insp_valid),
        .insp_code(insp_code), .sort_valid(sort_valid), .sort_code(sort_code),
        .eject(eject), .fill_count(fill_count), .overflow_err(overflow_err),
        .underflow_err(underflow_err)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input int code);
        @(negedge clk);
        insp_valid = 1'b1;
        insp_code = CODE_W'(code);
        @(negedge clk);
        insp_valid = 1'b0;
    endtask

    task automatic arrive();
        @(negedge clk);
        eye_raw = 1'b1;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic leave();
        @(negedge clk);
        eye_raw = 1'b0;
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 count", int'(fill_count), 0);
        check("R1 sort_valid", int'(sort_valid), 0);
        check("R1 eject", int'(eject), 0);
        check("R1 flags", int'({overflow_err, underflow_err}), 0);
    endtask

    task automatic t_load_and_first();
        load(2); load(1); load(5);
        check("R2 count", int'(fill_count), 3);
        arrive();
        check("R3 count", int'(fill_count), 2);
        check("R7 sort_valid", int'(sort_valid), 1);
        check("R7 sort_code", int'(sort_code), 2);
        check("R8 no eject", int'(eject), 0);
        leave();
        check("R7 cleared", int'(sort_valid), 0);
    endtask

    task automatic t_reject_hold();
        arrive();
        check("R2 order code", int'(sort_code), 1);
        check("R8 eject on", int'(eject), 1);
        load(6);
        check("R9 code held", int'(sort_code), 1);
        check("R9 eject held", int'(eject), 1);
        check("R12 count", int'(fill_count), 2);
        leave();
        check("R8 eject off", int'(eject), 0);
    endtask

    task automatic t_glitch();
        @(negedge clk);
        eye_raw = 1'b1;
        repeat (2) @(negedge clk);
        eye_raw = 1'b0;
        repeat (SETTLE) @(negedge clk);
        check("R5 count", int'(fill_count), 2);
        check("R5 sort_valid", int'(sort_valid), 0);
    endtask

    task automatic t_both_and_long();
        // stack holds 5,6; unload pulse reaches the stack on the clock DB+3 after eye rises
        @(negedge clk);
        eye_raw = 1'b1;
        repeat (DB + 2) @(posedge clk);
        @(negedge clk);
        insp_valid = 1'b1;
        insp_code = 3'd4;
        @(negedge clk);
        insp_valid = 1'b0;
        repeat (40) @(negedge clk);
        check("R4 count kept", int'(fill_count), 2);
        check("R4 code", int'(sort_code), 5);
        check("R6 one unload", int'(fill_count), 2);
        leave();
        arrive();
        check("R4 next", int'(sort_code), 6);
        leave();
        arrive();
        check("R4 order", int'(sort_code), 4);
        check("R12 empty", int'(fill_count), 0);
        leave();
    endtask

    task automatic t_underflow();
        check("R11 flag before", int'(underflow_err), 0);
        arrive();
        check("R11 flag", int'(underflow_err), 1);
        check("R11 no action", int'(sort_valid), 0);
        leave();
        check("R11 sticky", int'(underflow_err), 1);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++) load(i);
        check("R12 full", int'(fill_count), DEPTH);
        check("R10 flag before", int'(overflow_err), 0);
        load(3);
        check("R10 flag", int'(overflow_err), 1);
        check("R10 count", int'(fill_count), DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            arrive();
            check("R10 contents", int'(sort_code), i);
            check("R8 eject by code", int'(eject), (i == 1) ? 1 : 0);
            leave();
        end
        check("R10 sticky", int'(overflow_err), 1);
        check("R12 drained", int'(fill_count), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_load_and_first();
        t_reject_hold();
        t_glitch();
        t_both_and_long();
        t_underflow();
        t_overflow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule